// File: doc/BRIEF.md
# Programmable Readout Burst Generator

This block emits bursts of 16-bit data words, one word per clock, for a readout sequence. Bursts are produced while a run bit is set. Each burst ends with a last-word flag unless that flag is suppressed by configuration. When the run bit is cleared, the burst in progress still completes, and no further burst begins.

A small register-write port holds the settings:

- **Burst length:** either taken from a length register, or drawn from a pseudo-random source and limited by a mask. The length is clamped to at least two words. It is optionally rounded up to a multiple of three.
- **Data mode:** a running sequence count, pseudo-random words, or zeros.
- **Tester ID:** an optional 8-bit ID that is stamped into the sequence pattern.

Pseudo-random data and random lengths share one 16-bit maximal-length LFSR. The LFSR steps once for each value it supplies.

Top module: `rbg_burst_gen`

## Requirements
- R1: After reset, `dout_valid` and `dout_last` are 0. The sequence count starts at 0 and the LFSR starts at 0xACE1.
- R2: Register addresses are 0 control, 1 length, 2 mask, 3 tester ID and 4 run. Other addresses are ignored. Writing address 4 with bit 7 = 1 starts burst generation. Writing it with bit 7 = 0 stops generation once the current burst ends, and no `dout_valid` follows until the next start.
- R3: With control bit 3 = 0, the burst length is the length register value. Any value below 2 gives a 2-word burst.
- R4: With control bit 3 = 1, the length is the current LFSR value ANDed with the inverse of the mask register, clamped to at least 2. The LFSR steps once for this draw.
- R5: With control bit 6 = 0, the length after R3/R4 is rounded up to the next multiple of 3. With bit 6 = 1, no rounding is applied.
- R6: `dout_last` is high only together with `dout_valid`, and only on the final word of a burst.
- R7: With control bit 2 = 1, `dout_last` is never asserted.
- R8: Control bits 1-0 = 01 selects sequence mode. Each word is the sequence count, which then increments. The count carries over between bursts.
- R9: In sequence mode, when the tester ID register is nonzero, word positions 1, 4, 7, ... of a burst (position mod 3 = 1) carry the ID in bits 15-8.
- R10: Control bits 1-0 = 10 selects LFSR mode. Each word is the current LFSR state, after which the LFSR steps. The LFSR is a right-shifting Galois register with tap mask 0xB400.
- R11: Control bits 1-0 = 00 or 11 produces all-zero words with the normal valid and last timing.
- R12: While run stays set, the next burst starts after exactly one idle cycle. The mode and last-suppression settings are captured at the start of each burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| dout | output | 16 | Burst data word |
| dout_valid | output | 1 | Word on `dout` is valid |
| dout_last | output | 1 | Final word of a burst |

## Verification
Directed bursts cover the boundary lengths:

- a programmed length of 0, which separates the clamp to 2 from a pass-through;
- length 7 with and without rounding, which separates the rounding step from the raw value;
- a nonzero ID over two cells, which shows that only the second word of each cell is stamped.

Each data mode is run on its own, so sequence, LFSR and zero words cannot be confused. A back-to-back pair of bursts confirms that the one-cycle gap holds and that the sequence count and LFSR continue across the pair.

Randomized configurations then mix every control bit, mask and length. Each one is checked against a bench model that tracks the LFSR and sequence state. A wrong draw order or a missed LFSR step therefore shows up in every later word.

// File: rtl/rbg_pkg.sv
package rbg_pkg;

  localparam int DW  = 16;
  localparam int IDW = 8;
  localparam int AW  = 3;

  localparam logic [AW-1:0] A_CTRL = 3'd0;
  localparam logic [AW-1:0] A_LEN  = 3'd1;
  localparam logic [AW-1:0] A_MASK = 3'd2;
  localparam logic [AW-1:0] A_ID   = 3'd3;
  localparam logic [AW-1:0] A_RUN  = 3'd4;

  localparam int MIN_LEN = 2;
  localparam int CELL    = 3;

  typedef enum logic [1:0] {
    MODE_ZERO = 2'b00,
    MODE_SEQ  = 2'b01,
    MODE_PRNG = 2'b10,
    MODE_RSVD = 2'b11
  } mode_e;

  typedef struct packed {
    logic  keep_len;   // control bit 6
    logic  rand_len;   // control bit 3
    logic  no_end;     // control bit 2
    mode_e mode;       // control bits 1-0
  } cfg_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SIZE = 2'd1,
    ST_EMIT = 2'd2
  } st_e;

  function automatic logic [DW-1:0] lfsr_step(input logic [DW-1:0] s,
                                               input logic [DW-1:0] taps);
    return s[0] ? ((s >> 1) ^ taps) : (s >> 1);
  endfunction

  function automatic logic [DW-1:0] clamp_min(input logic [DW-1:0] v);
    return (v < DW'(MIN_LEN)) ? DW'(MIN_LEN) : v;
  endfunction

  function automatic logic [DW-1:0] round_cell(input logic [DW-1:0] v);
    logic [1:0] rem;
    rem = 2'(v % DW'(CELL));
    case (rem)
      2'd1:    return v + DW'(2);
      2'd2:    return v + DW'(1);
      default: return v;
    endcase
  endfunction

  function automatic logic [DW-1:0] make_word(input mode_e mode,
                                              input logic [DW-1:0] seq,
                                              input logic [DW-1:0] rnd,
                                              input logic [IDW-1:0] id,
                                              input logic second);
    logic [DW-1:0] w;
    case (mode)
      MODE_SEQ: begin
        w = seq;
        if (second && (id != '0)) w[DW-1 -: IDW] = id;
      end
      MODE_PRNG: w = rnd;
      default:   w = '0;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/rbg_regs.sv
module rbg_regs
  import rbg_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  output cfg_t            cfg,
  output logic [DW-1:0]   len_reg,
  output logic [DW-1:0]   mask_reg,
  output logic [IDW-1:0]  id_reg,
  output logic            run
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg      <= '0;
      len_reg  <= '0;
      mask_reg <= '0;
      id_reg   <= '0;
      run      <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL: cfg <= '{keep_len: wr_data[6], rand_len: wr_data[3],
                         no_end: wr_data[2], mode: mode_e'(wr_data[1:0])};
        A_LEN:  len_reg  <= wr_data;
        A_MASK: mask_reg <= wr_data;
        A_ID:   id_reg   <= wr_data[IDW-1:0];
        A_RUN:  run      <= wr_data[7];
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/rbg_lfsr.sv
module rbg_lfsr
  import rbg_pkg::*;
#(
  parameter logic [DW-1:0] SEED = 16'hACE1,
  parameter logic [DW-1:0] TAPS = 16'hB400
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [DW-1:0] state
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   state <= SEED;
    else if (adv) state <= lfsr_step(state, TAPS);
  end

endmodule

// File: rtl/rbg_sizer.sv
module rbg_sizer
  import rbg_pkg::*;
(
  input  cfg_t          cfg,
  input  logic [DW-1:0] len_reg,
  input  logic [DW-1:0] mask_reg,
  input  logic [DW-1:0] rnd,
  output logic [DW-1:0] burst_len
);

  logic [DW-1:0] raw_len;
  logic [DW-1:0] floor_len;

  always_comb begin
    raw_len   = cfg.rand_len ? (rnd & ~mask_reg) : len_reg;
    floor_len = clamp_min(raw_len);
    burst_len = cfg.keep_len ? floor_len : round_cell(floor_len);
  end

endmodule

// File: rtl/rbg_word.sv
module rbg_word
  import rbg_pkg::*;
(
  input  mode_e          mode,
  input  logic [DW-1:0]  seq,
  input  logic [DW-1:0]  rnd,
  input  logic [IDW-1:0] id,
  input  logic [1:0]     cell_pos,
  output logic [DW-1:0]  word
);

  always_comb word = make_word(mode, seq, rnd, id, cell_pos == 2'd1);

endmodule

// File: rtl/rbg_burst_gen.sv
module rbg_burst_gen
  import rbg_pkg::*;
#(
  parameter logic [15:0] LFSR_SEED = 16'hACE1,
  parameter logic [15:0] LFSR_TAPS = 16'hB400
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [15:0] wr_data,
  output logic [15:0] dout,
  output logic        dout_valid,
  output logic        dout_last
);

  cfg_t           cfg;
  logic [DW-1:0]  len_reg, mask_reg, burst_len;
  logic [IDW-1:0] id_reg;
  logic           run;
  logic [DW-1:0]  lfsr_q;
  logic           lfsr_adv;

  st_e            state;
  logic [DW-1:0]  cur_len;
  logic [DW-1:0]  idx;
  logic [1:0]     cell_pos;
  mode_e          mode_q;
  logic           sup_q;
  logic [DW-1:0]  seq_cnt;
  logic [DW-1:0]  word;

  // named events for the checker
  logic ev_size, ev_emit, ev_end, seq_adv, keep_len;

  rbg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cfg(cfg), .len_reg(len_reg), .mask_reg(mask_reg),
    .id_reg(id_reg), .run(run)
  );

  rbg_lfsr #(.SEED(LFSR_SEED), .TAPS(LFSR_TAPS)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .adv(lfsr_adv), .state(lfsr_q)
  );

  rbg_sizer u_sizer (
    .cfg(cfg), .len_reg(len_reg), .mask_reg(mask_reg), .rnd(lfsr_q),
    .burst_len(burst_len)
  );

  rbg_word u_word (
    .mode(mode_q), .seq(seq_cnt), .rnd(lfsr_q), .id(id_reg),
    .cell_pos(cell_pos), .word(word)
  );

  assign ev_size  = (state == ST_SIZE);
  assign ev_emit  = (state == ST_EMIT);
  assign ev_end   = ev_emit && (idx == cur_len - DW'(1));
  assign seq_adv  = ev_emit && (mode_q == MODE_SEQ);
  assign keep_len = cfg.keep_len;
  assign lfsr_adv = (ev_size && cfg.rand_len) || (ev_emit && mode_q == MODE_PRNG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cur_len  <= DW'(MIN_LEN);
      idx      <= '0;
      cell_pos <= '0;
      mode_q   <= MODE_ZERO;
      sup_q    <= 1'b0;
      seq_cnt  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (run) state <= ST_SIZE;
        ST_SIZE: begin
          cur_len  <= burst_len;
          mode_q   <= cfg.mode;
          sup_q    <= cfg.no_end;
          idx      <= '0;
          cell_pos <= '0;
          state    <= ST_EMIT;
        end
        ST_EMIT: begin
          idx      <= idx + DW'(1);
          cell_pos <= (cell_pos == 2'(CELL - 1)) ? 2'd0 : cell_pos + 2'd1;
          if (seq_adv) seq_cnt <= seq_cnt + DW'(1);
          if (ev_end)  state <= run ? ST_SIZE : ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign dout       = ev_emit ? word : '0;
  assign dout_valid = ev_emit;
  assign dout_last  = ev_end && !sup_q;

endmodule

// File: rtl/rbg_burst_gen_chk.sv
module rbg_burst_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        dout_valid,
  input logic        dout_last,
  input logic        ev_size,
  input logic        ev_end,
  input logic        run,
  input logic        keep_len,
  input logic        sup_q,
  input logic [15:0] cur_len,
  input logic        seq_adv,
  input logic [15:0] seq_cnt,
  input logic [15:0] lfsr_q
);

  AST_RESET_QUIET: assert property (@(posedge clk) $rose(rst_n) |-> !dout_valid && !dout_last); // R1
  AST_STOP_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n) ev_end && !run |=> !dout_valid); // R2
  AST_MIN_LEN: assert property (@(posedge clk) disable iff (!rst_n) ev_size |=> cur_len >= 16'd2); // R3
  AST_ROUND_CELL: assert property (@(posedge clk) disable iff (!rst_n) ev_size && !keep_len |=> (cur_len % 16'd3) == 16'd0); // R5
  AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n) dout_last |-> dout_valid); // R6
  AST_NO_END_FLAG: assert property (@(posedge clk) disable iff (!rst_n) sup_q && dout_valid |-> !dout_last); // R7
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n) seq_adv |=> seq_cnt == $past(seq_cnt) + 16'd1); // R8
  AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n) lfsr_q != 16'd0); // R10
  AST_GAP_ONE: assert property (@(posedge clk) disable iff (!rst_n) ev_end && run |=> ev_size); // R12

endmodule

bind rbg_burst_gen rbg_burst_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dout_valid(dout_valid), .dout_last(dout_last),
  .ev_size(ev_size), .ev_end(ev_end), .run(run), .keep_len(keep_len),
  .sup_q(sup_q), .cur_len(cur_len), .seq_adv(seq_adv), .seq_cnt(seq_cnt),
  .lfsr_q(lfsr_q)
);

// File: tb/rbg_burst_gen_test.sv
`timescale 1ns/1ps
module rbg_burst_gen_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] dout;
  logic        dout_valid, dout_last;

  always #2 clk = ~clk;

  rbg_burst_gen uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .dout(dout), .dout_valid(dout_valid),
    .dout_last(dout_last)
  );

  int n_chk = 0, n_fail = 0;
  logic [15:0] m_lfsr = 16'hACE1;
  logic [15:0] m_seq  = 16'h0000;
  logic [15:0] exp_w [0:79];
  logic        exp_l [0:79];
  logic [15:0] cap_w [0:79];
  logic        cap_l [0:79];
  int          exp_n, cap_n;

  function automatic logic [15:0] b_next(input logic [15:0] s);
    logic fb;
    fb = s[0];
    s = {1'b0, s[15:1]};
    if (fb) s = s ^ 16'hB400;
    return s;
  endfunction

  function automatic int b_fix_len(input int v, input logic keep);
    int r;
    r = (v < 2) ? 2 : v;
    if (!keep) r = ((r + 2) / 3) * 3;
    return r;
  endfunction

  task automatic check(input logic ok, input string tag, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // caller is at a negedge; write lands at the next posedge
  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic configure(input logic [15:0] ctrl, input logic [15:0] len,
                           input logic [15:0] mask, input logic [7:0] id);
    wr(3'd0, ctrl); wr(3'd1, len); wr(3'd2, mask); wr(3'd3, {8'h00, id});
  endtask

  task automatic model(input logic [15:0] ctrl, input logic [15:0] len,
                       input logic [15:0] mask, input logic [7:0] id);
    int v;
    logic [15:0] w;
    if (ctrl[3]) begin
      v = int'(m_lfsr & ~mask);
      m_lfsr = b_next(m_lfsr);
    end else v = int'(len);
    exp_n = b_fix_len(v, ctrl[6]);
    for (int i = 0; i < exp_n; i++) begin
      case (ctrl[1:0])
        2'b01: begin
          w = m_seq;
          if (id != 8'h00 && (i % 3) == 1) w[15:8] = id;
          m_seq = m_seq + 16'd1;
        end
        2'b10: begin w = m_lfsr; m_lfsr = b_next(m_lfsr); end
        default: w = 16'h0000;
      endcase
      exp_w[i] = w;
      exp_l[i] = (i == exp_n - 1) && !ctrl[2];
    end
  endtask

  task automatic capture();
    int waits = 0;
    cap_n = 0;
    while (!dout_valid && waits < 20) begin @(negedge clk); waits++; end
    while (dout_valid && cap_n < 80) begin
      cap_w[cap_n] = dout; cap_l[cap_n] = dout_last; cap_n++;
      @(negedge clk);
    end
  endtask

  task automatic compare(input logic [15:0] ctrl);
    string lt, dt, ft;
    lt = ctrl[3] ? "R4" : (!ctrl[6] ? "R5" : "R3");
    dt = (ctrl[1:0] == 2'b01) ? "R8" : ((ctrl[1:0] == 2'b10) ? "R10" : "R11");
    ft = ctrl[2] ? "R7" : "R6";
    check(cap_n == exp_n, lt, "burst length", cap_n, exp_n);
    for (int i = 0; i < exp_n && i < cap_n; i++) begin
      check(cap_w[i] == exp_w[i], dt, $sformatf("word %0d", i), cap_w[i], exp_w[i]);
      check(cap_l[i] == exp_l[i], ft, $sformatf("last flag %0d", i), cap_l[i], exp_l[i]);
    end
  endtask

  task automatic idle_check();
    for (int k = 0; k < 3; k++) begin
      check(!dout_valid, "R2", "no word after stop", dout_valid, 0);
      @(negedge clk);
    end
  endtask

  task automatic one_burst(input logic [15:0] ctrl, input logic [15:0] len,
                           input logic [15:0] mask, input logic [7:0] id);
    configure(ctrl, len, mask, id);
    model(ctrl, len, mask, id);
    wr(3'd4, 16'h0080);
    wr(3'd4, 16'h0000);
    capture();
    compare(ctrl);
    idle_check();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R2: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] masks [0:3];
    masks[0] = 16'hFFF0; masks[1] = 16'hFFE0; masks[2] = 16'hFFFC; masks[3] = 16'hFFC0;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!dout_valid && !dout_last, "R1", "outputs in reset", {dout_valid, dout_last}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!dout_valid && !dout_last, "R1", "outputs after reset", {dout_valid, dout_last}, 0);
    // R2: unused address and idle
    wr(3'd7, 16'hFFFF);
    idle_check();

    one_burst(16'h0041, 16'd5, 16'h0000, 8'h00);   // R3 R6 R8 fixed 5
    one_burst(16'h0041, 16'd0, 16'h0000, 8'h00);   // R3 clamp to 2
    one_burst(16'h0001, 16'd7, 16'h0000, 8'h00);   // R5 7 -> 9
    one_burst(16'h0041, 16'd7, 16'h0000, 8'h00);   // R5 no rounding
    one_burst(16'h0041, 16'd6, 16'h0000, 8'hA5);   // R9 ID stamp
    one_burst(16'h0042, 16'd4, 16'h0000, 8'h00);   // R10 LFSR words
    one_burst(16'h0045, 16'd5, 16'h0000, 8'h00);   // R7 no last
    one_burst(16'h004A, 16'd0, 16'hFFF0, 8'h00);   // R4 random length
    one_burst(16'h0040, 16'd4, 16'h0000, 8'h00);   // R11 zero mode
    one_burst(16'h0043, 16'd3, 16'h0000, 8'h00);   // R11 reserved mode

    // R12: back-to-back bursts with one gap cycle
    configure(16'h0041, 16'd4, 16'h0000, 8'h3C);
    model(16'h0041, 16'd4, 16'h0000, 8'h3C);
    wr(3'd4, 16'h0080);
    capture();
    compare(16'h0041);
    check(!dout_valid, "R12", "gap cycle idle", dout_valid, 0);
    model(16'h0041, 16'd4, 16'h0000, 8'h3C);
    wr(3'd4, 16'h0000);
    check(dout_valid, "R12", "second burst after one gap", dout_valid, 1);
    capture();
    compare(16'h0041);
    idle_check();

    for (int it = 0; it < 24; it++) begin
      logic [15:0] c;
      c = 16'h0000;
      c[6] = 1'($urandom_range(0, 1));
      c[3] = 1'($urandom_range(0, 1));
      c[2] = 1'($urandom_range(0, 1));
      c[1:0] = 2'($urandom_range(0, 3));
      one_burst(c, 16'($urandom_range(0, 40)), masks[$urandom_range(0, 3)],
                ($urandom_range(0, 1) == 1) ? 8'($urandom_range(1, 255)) : 8'h00);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule